// File: doc/BRIEF.md
# Software-Triggered SMI Port Trap

This block watches the processor's I/O write cycles for one programmable 16-bit port address. Software arms the trap and picks where the event goes: a system management interrupt, or one of two legacy interrupt lines (IRQ12 or IRQ15). When an armed trap sees a write to the programmed port, it sends a single-cycle pulse on the selected output.

Each trapped write also does two more things:
- It sets a sticky status flag that software clears by writing a one to it.
- It raises a soft-reset mask output. A write to a separate configuration index drops the mask again.

The address bytes and the routing and enable bits come in from the configuration register file as plain fields. The block itself contains only the matching logic, the routing, the status flag and the mask.

Top module: `io_trap_smi`

## Requirements
- R1: The trap port is `{trap_addr_hi, trap_addr_lo}`. A trapped event happens only for an I/O write cycle (`io_wr`=1) whose `io_addr` equals that value exactly. Any other address produces no pulse and changes no state.
- R2: The trap is armed only when `trap_en` and `swsmi_en` are both 1. A write to the port while either one is 0 produces no pulse, leaves `status` unchanged and leaves `soft_rst_mask` unchanged.
- R3: A trapped event is routed by the configuration fields as follows:
  - If `route_smi`=1, `smi_pulse` rises.
  - Otherwise, if `route_irq15`=1, `irq15_pulse` rises.
  - Otherwise `irq12_pulse` rises.
- R4: The selected pulse is high for exactly the one cycle after the clock edge that samples the write. At most one of the three pulse outputs is ever high.
- R5: An I/O read cycle (`io_rd`=1, `io_wr`=0) to the trap port never triggers the trap.
- R6: Every trapped event sets `status[1]`, in the same cycle as the pulse.
- R7: Every trapped event sets `soft_rst_mask`, in the same cycle as the pulse.
- R8: A register write (`reg_wr`=1) with `reg_sel`=8'h19 clears each `status` bit whose `reg_wdata` bit is 1 and leaves all other bits unchanged. If a trapped event falls in the same cycle, `status[1]` ends up set.
- R9: A register write with `reg_sel`=8'h1C clears `soft_rst_mask`, whatever the data. If a trapped event falls in the same cycle, the mask ends up set.
- R10: While `rst_n` is low, all pulses are 0, `status` is 8'h00 and `soft_rst_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write cycle strobe |
| io_rd | input | 1 | I/O read cycle strobe |
| io_addr | input | 16 | I/O cycle port address |
| trap_addr_lo | input | 8 | Trap port, low byte |
| trap_addr_hi | input | 8 | Trap port, high byte |
| trap_en | input | 1 | Trap enable, first half of the arm condition |
| swsmi_en | input | 1 | Software SMI enable, second half of the arm condition |
| route_smi | input | 1 | Route the event to SMI |
| route_irq15 | input | 1 | If not routed to SMI: 1 selects IRQ15, 0 selects IRQ12 |
| reg_wr | input | 1 | Configuration register write strobe |
| reg_sel | input | 8 | Configuration register index |
| reg_wdata | input | 8 | Configuration register write data |
| smi_pulse | output | 1 | SMI request pulse |
| irq12_pulse | output | 1 | IRQ12 request pulse |
| irq15_pulse | output | 1 | IRQ15 request pulse |
| status | output | 8 | Sticky status; bit 1 records a trapped event |
| soft_rst_mask | output | 1 | Soft-reset mask |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: a trapped write arriving in the same cycle as a write-one-to-clear of the status, or as a mask-clear write. Both strobes have to be held in the same clock cycle. The bench has a task that raises `io_wr` and `reg_wr` together, so the set-wins priority of R8 and R9 is checked directly. Back-to-back trapped writes with the routing changed between them show that each write yields its own one-cycle pulse on the newly selected line.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
    localparam int STS_W = 8;

    typedef struct packed {
        logic             smi;
        logic             irq12;
        logic             irq15;
        logic [STS_W-1:0] sts;
        logic             mask;
    } trap_state_t;

    typedef struct packed {
        logic smi;
        logic irq12;
        logic irq15;
    } trap_route_t;
endpackage

// File: rtl/io_trap_match.sv
module io_trap_match #(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              wr,
    input  logic              armed,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] trap_addr,
    output logic              hit
);
    localparam int N_LANES = ADDR_W / LANE_W;

    logic [N_LANES-1:0] lane_eq;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_eq[g] = (addr[g*LANE_W +: LANE_W] == trap_addr[g*LANE_W +: LANE_W]);
    end

    assign hit = wr && armed && (&lane_eq);
endmodule

// File: rtl/io_trap_route.sv
module io_trap_route
    import io_trap_pkg::*;
(
    input  logic        hit,
    input  logic        to_smi,
    input  logic        to_irq15,
    output trap_route_t route
);
    always_comb begin
        route       = '0;
        route.smi   = hit && to_smi;
        route.irq15 = hit && !to_smi && to_irq15;
        route.irq12 = hit && !to_smi && !to_irq15;
    end
endmodule

// File: rtl/io_trap_smi.sv
module io_trap_smi
    import io_trap_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter int                 LANE_W   = 8,
    parameter int                 SEL_W    = 8,
    parameter logic [SEL_W-1:0]   STS_IDX  = 8'h19,
    parameter logic [SEL_W-1:0]   MASK_IDX = 8'h1C,
    parameter int                 FLAG_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [LANE_W-1:0] trap_addr_lo,
    input  logic [LANE_W-1:0] trap_addr_hi,
    input  logic              trap_en,
    input  logic              swsmi_en,
    input  logic              route_smi,
    input  logic              route_irq15,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [STS_W-1:0]  reg_wdata,
    output logic              smi_pulse,
    output logic              irq12_pulse,
    output logic              irq15_pulse,
    output logic [STS_W-1:0]  status,
    output logic              soft_rst_mask
);
    trap_state_t st_d, st_q;
    trap_route_t route;
    logic        trap_hit;
    logic        io_cycle_rd_only;

    // Reads are decoded only to make explicit that they never reach the trap.
    assign io_cycle_rd_only = io_rd && !io_wr;

    io_trap_match #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) u_match (
        .wr        (io_wr),
        .armed     (trap_en && swsmi_en),
        .addr      (io_addr),
        .trap_addr ({trap_addr_hi, trap_addr_lo}),
        .hit       (trap_hit)
    );

    io_trap_route u_route (
        .hit      (trap_hit),
        .to_smi   (route_smi),
        .to_irq15 (route_irq15),
        .route    (route)
    );

    always_comb begin
        st_d       = st_q;
        st_d.smi   = route.smi;
        st_d.irq12 = route.irq12;
        st_d.irq15 = route.irq15;
        if (reg_wr && (reg_sel == STS_IDX))
            st_d.sts = st_q.sts & ~reg_wdata;
        if (reg_wr && (reg_sel == MASK_IDX))
            st_d.mask = 1'b0;
        if (trap_hit) begin
            st_d.sts[FLAG_BIT] = 1'b1;
            st_d.mask          = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smi_pulse     = st_q.smi;
    assign irq12_pulse   = st_q.irq12;
    assign irq15_pulse   = st_q.irq15;
    assign status        = st_q.sts;
    assign soft_rst_mask = st_q.mask;

    // R4: at most one request line high at a time
    p_pulse_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smi_pulse, irq12_pulse, irq15_pulse}));

    // R6: a pulse is always accompanied by the status flag
    p_flag_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_pulse || irq12_pulse || irq15_pulse) |-> status[FLAG_BIT]);

    // R7: a pulse is always accompanied by the mask
    p_mask_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_pulse || irq12_pulse || irq15_pulse) |-> soft_rst_mask);

    // R2: disarmed trap never pulses
    p_disarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_en && swsmi_en) |=> !(smi_pulse || irq12_pulse || irq15_pulse));

    // R5: a read-only cycle never triggers
    p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_cycle_rd_only |=> !(smi_pulse || irq12_pulse || irq15_pulse));

    // R9: mask-clear write without a trap drops the mask
    p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == MASK_IDX) && !trap_hit) |=> !soft_rst_mask);

    // R8: status bits written as zero keep their value
    p_w1c_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == STS_IDX) && !trap_hit) |=>
            (status == ($past(status) & ~$past(reg_wdata))));
endmodule

// File: tb/io_trap_smi_tb.sv
module io_trap_smi_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  trap_addr_lo = 8'h00, trap_addr_hi = 8'h00;
    logic        trap_en = 1'b0, swsmi_en = 1'b0, route_smi = 1'b0, route_irq15 = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_sel = '0, reg_wdata = '0;
    logic        smi_pulse, irq12_pulse, irq15_pulse, soft_rst_mask;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    io_trap_smi dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .trap_addr_lo(trap_addr_lo), .trap_addr_hi(trap_addr_hi),
        .trap_en(trap_en), .swsmi_en(swsmi_en), .route_smi(route_smi),
        .route_irq15(route_irq15), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .smi_pulse(smi_pulse), .irq12_pulse(irq12_pulse),
        .irq15_pulse(irq15_pulse), .status(status), .soft_rst_mask(soft_rst_mask)
    );

    // Behavioural reference model, updated on every edge
    logic       m_smi = 0, m_i12 = 0, m_i15 = 0, m_mask = 0;
    logic [7:0] m_sts = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_smi <= 0; m_i12 <= 0; m_i15 <= 0; m_mask <= 0; m_sts <= 0;
        end else begin
            bit         fire;
            logic [7:0] ns;
            logic       nm;
            fire = io_wr && trap_en && swsmi_en && (io_addr == {trap_addr_hi, trap_addr_lo});
            ns = m_sts;
            nm = m_mask;
            if (reg_wr && reg_sel == 8'h19) ns = ns & ~reg_wdata;
            if (reg_wr && reg_sel == 8'h1C) nm = 1'b0;
            if (fire) begin ns[1] = 1'b1; nm = 1'b1; end
            m_sts  <= ns;
            m_mask <= nm;
            m_smi  <= fire && route_smi;
            m_i15  <= fire && !route_smi && route_irq15;
            m_i12  <= fire && !route_smi && !route_irq15;
        end
    end

    always @(negedge clk) begin
        checks++;
        if ({smi_pulse, irq12_pulse, irq15_pulse, status, soft_rst_mask} !==
            {m_smi, m_i12, m_i15, m_sts, m_mask}) begin
            errors++;
            $display("FAIL model R3 R6 R7 R8 R9: actual %b_%b_%b_%h_%b expected %b_%b_%b_%h_%b",
                     smi_pulse, irq12_pulse, irq15_pulse, status, soft_rst_mask,
                     m_smi, m_i12, m_i15, m_sts, m_mask);
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        io_wr = 0; io_rd = 0; reg_wr = 0;
    endtask

    task automatic io_write(input logic [15:0] a);
        io_addr = a; io_wr = 1; step();
    endtask

    task automatic io_read(input logic [15:0] a);
        io_addr = a; io_rd = 1; step();
    endtask

    task automatic reg_write(input logic [7:0] s, input logic [7:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1; step();
    endtask

    task automatic both_write(input logic [15:0] a, input logic [7:0] s, input logic [7:0] d);
        io_addr = a; io_wr = 1; reg_sel = s; reg_wdata = d; reg_wr = 1; step();
    endtask

    function automatic logic [2:0] pulses();
        return {smi_pulse, irq12_pulse, irq15_pulse};
    endfunction

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset pulses", {13'd0, pulses()}, 16'd0);
        check("R10 reset status", {8'd0, status}, 16'd0);
        check("R10 reset mask", {15'd0, soft_rst_mask}, 16'd0);
        rst_n = 1;
        step();

        trap_addr_lo = 8'hB2; trap_addr_hi = 8'h04;
        io_write(16'h04B2);
        check("R2 disarmed no pulse", {13'd0, pulses()}, 16'd0);
        check("R2 disarmed status", {8'd0, status}, 16'd0);

        trap_en = 1; io_write(16'h04B2);
        check("R2 half armed", {13'd0, pulses()}, 16'd0);
        trap_en = 0; swsmi_en = 1; io_write(16'h04B2);
        check("R2 other half armed", {15'd0, soft_rst_mask}, 16'd0);
        trap_en = 1;

        io_write(16'h00B2);
        check("R1 wrong high byte", {13'd0, pulses()}, 16'd0);
        io_write(16'h04B3);
        check("R1 wrong low byte", {8'd0, status}, 16'd0);

        io_read(16'h04B2);
        check("R5 read ignored", {13'd0, pulses()}, 16'd0);
        check("R5 read no mask", {15'd0, soft_rst_mask}, 16'd0);

        io_write(16'h04B2);
        check("R3 irq12 route", {13'd0, pulses()}, 16'h2);
        check("R6 flag set", {15'd0, status[1]}, 16'd1);
        check("R7 mask set", {15'd0, soft_rst_mask}, 16'd1);
        step();
        check("R4 single cycle", {13'd0, pulses()}, 16'd0);

        route_irq15 = 1; io_write(16'h04B2);
        check("R3 irq15 route", {13'd0, pulses()}, 16'h1);
        route_smi = 1; io_write(16'h04B2);
        check("R4 back to back smi", {13'd0, pulses()}, 16'h4);
        route_smi = 0; route_irq15 = 0;
        step();

        reg_write(8'h19, 8'hFD);
        check("R8 zero bit kept", {8'd0, status}, 16'h02);
        reg_write(8'h18, 8'hFF);
        check("R8 other index no clear", {8'd0, status}, 16'h02);
        reg_write(8'h19, 8'h02);
        check("R8 w1c clears", {8'd0, status}, 16'h00);
        check("R9 mask survives status clear", {15'd0, soft_rst_mask}, 16'd1);

        reg_write(8'h1C, 8'h00);
        check("R9 mask cleared", {15'd0, soft_rst_mask}, 16'd0);

        both_write(16'h04B2, 8'h19, 8'h02);
        check("R8 set wins over clear", {8'd0, status}, 16'h02);
        both_write(16'h04B2, 8'h1C, 8'h55);
        check("R9 set wins over mask clear", {15'd0, soft_rst_mask}, 16'd1);

        trap_addr_lo = 8'h34; trap_addr_hi = 8'h12;
        io_write(16'h04B2);
        check("R1 old address ignored", {13'd0, pulses()}, 16'd0);
        io_write(16'h1234);
        check("R1 new address", {13'd0, pulses()}, 16'h2);

        for (int k = 0; k < 40; k++) begin
            route_smi = k[0]; route_irq15 = k[1];
            if (k % 3 == 0) reg_write(8'h19, 8'(k * 37));
            else if (k % 5 == 0) reg_write(8'h1C, 8'h00);
            else io_write((k % 4 == 0) ? 16'h1234 : 16'h1200 + 16'(k));
        end

        rst_n = 0; step(); rst_n = 1;
        check("R10 re-reset status", {8'd0, status}, 16'd0);
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule